// File: doc/BRIEF.md
# Scan Tree with Inverting and XOR Links

This block is a scan structure that replaces one long shift chain with a shallow tree of storage cells. A single serial scan input feeds the first level. Every later cell takes its shift data from earlier cells, in one of four ways:

- a straight copy of one cell;
- an inverted copy of one cell;
- the XOR of two cells;
- the XOR of one cell with the complement of another.

Cells whose test bits always agree, always disagree, or always match such a parity relation can therefore share one shift slot. The tree is only as deep as its number of levels, so a pattern loads in that many shift cycles rather than one cycle per cell.

With scan enable low, every cell loads its functional input on the clock edge. A fixed set of cells is tapped onto the scan outputs, where a response compactor outside the block can collect them. The connectivity is a parameter table. Each entry holds the link kind and up to two source indices, and index N stands for the scan input.

The default configuration has 9 cells in 3 levels and 4 scan outputs. It uses two copy links from the scan input, one inverting link from the scan input, one plain copy at level 2 and one at level 3, two inverting links at level 2, one XOR link and one inverted-operand XOR link.

Top module: `scan_tree`

## Requirements
- R1: While rst_n is low at a rising clock edge, every cell clears to 0, so q and scan_out read 0 after that edge.
- R2: With rst_n high and scan_enable low, q equals the func_d value that was present at the previous rising edge.
- R3: With rst_n high and scan_enable high, a copy link (kind code 0) loads the previous value of its source A. The default copy cells are 0 and 2 (source is the scan input), 3 (source is cell 0) and 6 (source is cell 3).
- R4: In shift mode, an inverting link (kind code 1) loads the complement of its source A's previous value. The default inverting cells are 1 (source is the scan input), 4 (source is cell 0) and 5 (source is cell 2).
- R5: In shift mode, an XOR link (kind code 2) loads A XOR B of the previous values. The default XOR cell is 7, with A as cell 3 and B as cell 0.
- R6: In shift mode, an inverted-operand XOR link (kind code 3) loads A XOR NOT B. The default cell is 8, with A as cell 4 and B as cell 2.
- R7: In the default tree, three shifts of the bits b1, b2 and b3 (b3 last) load the whole pattern from any prior state:
  - cells 0 and 2 hold b3, and cell 1 holds ~b3;
  - cell 3 holds b2, and cells 4 and 5 hold ~b2;
  - cell 6 holds b1;
  - cells 7 and 8 hold b1^b2.
- R8: scan_out[k] always equals the current value of the tapped cell. The default taps are bit 0 from cell 6, bit 1 from cell 7, bit 2 from cell 8 and bit 3 from cell 5.
- R9: A low rst_n takes priority over scan_enable: cells clear even while shifting is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| scan_in | input | 1 | Serial scan data into the first level |
| scan_enable | input | 1 | High selects shift data, low selects functional data |
| func_d | input | N | Functional data per cell |
| scan_out | output | M | Values of the tapped cells |
| q | output | N | Current cell contents |

## Verification
Capture is swept over all 512 func_d words, which shows that each cell loads its own functional bit and is not tied to a neighbour. Every 3-bit scan sequence is shifted in after a scrambled capture. The shift sequences separate copy links from inverting links and XOR links from inverted-operand XOR links, because those kinds disagree on some of the sequences. They also show that the whole pattern loads in the tree depth, independent of the earlier state. A long pseudo-random run then mixes shifting, capturing and resets, including resets asserted while shift is requested. In that run every cell and every tap is compared with a per-cycle model of the link table.

// File: rtl/scan_tree_pkg.sv
package scan_tree_pkg;

  typedef enum logic [1:0] {
    LK_COPY = 2'd0,
    LK_INV  = 2'd1,
    LK_XOR  = 2'd2,
    LK_XNOR = 2'd3
  } linkKind_e;

  // One entry per cell; a source index equal to the cell count means scan_in.
  typedef struct packed {
    linkKind_e   kind;
    logic [7:0]  srcA;
    logic [7:0]  srcB;
  } link_t;

  typedef struct packed {
    logic clear;
    logic shift;
    logic capture;
  } strobe_t;

  localparam int DEF_CELLS = 9;
  localparam int DEF_TAPS_N = 4;

  // Listed from cell 8 down to cell 0.
  localparam link_t [DEF_CELLS-1:0] DEF_LINKS = '{
    '{LK_XNOR, 8'd4, 8'd2},  // cell 8, level 3
    '{LK_XOR,  8'd3, 8'd0},  // cell 7, level 3
    '{LK_COPY, 8'd3, 8'd0},  // cell 6, level 3
    '{LK_INV,  8'd2, 8'd0},  // cell 5, level 2
    '{LK_INV,  8'd0, 8'd0},  // cell 4, level 2
    '{LK_COPY, 8'd0, 8'd0},  // cell 3, level 2
    '{LK_COPY, 8'd9, 8'd0},  // cell 2, level 1
    '{LK_INV,  8'd9, 8'd0},  // cell 1, level 1
    '{LK_COPY, 8'd9, 8'd0}   // cell 0, level 1
  };

  // Listed from tap 3 down to tap 0.
  localparam logic [DEF_TAPS_N-1:0][7:0] DEF_TAPS = '{8'd5, 8'd8, 8'd7, 8'd6};

endpackage

// File: rtl/scan_tree_ctrl.sv
module scan_tree_ctrl (
  input  logic                   rstN,
  input  logic                   scanEnable,
  output scan_tree_pkg::strobe_t stb
);
  always_comb begin
    stb.clear   = !rstN;
    stb.shift   = rstN && scanEnable;
    stb.capture = rstN && !scanEnable;
  end
endmodule

// File: rtl/scan_tree_links.sv
module scan_tree_links #(
  parameter int N = scan_tree_pkg::DEF_CELLS,
  parameter scan_tree_pkg::link_t [N-1:0] LINKS = scan_tree_pkg::DEF_LINKS
) (
  input  logic         scanIn,
  input  logic [N-1:0] cellQ,
  output logic [N-1:0] shiftD
);
  import scan_tree_pkg::*;

  logic [N:0] srcVec;
  assign srcVec = {scanIn, cellQ};

  function automatic logic pick(input logic [N:0] v, input int idx);
    return v[idx];
  endfunction

  for (genvar g = 0; g < N; g++) begin : gLink
    localparam int A = int'(LINKS[g].srcA);
    localparam int B = int'(LINKS[g].srcB);
    if (LINKS[g].kind == LK_COPY) begin : gCopy
      assign shiftD[g] = pick(srcVec, A);
    end else if (LINKS[g].kind == LK_INV) begin : gInv
      assign shiftD[g] = ~pick(srcVec, A);
    end else if (LINKS[g].kind == LK_XOR) begin : gXor
      assign shiftD[g] = pick(srcVec, A) ^ pick(srcVec, B);
    end else begin : gXnor
      assign shiftD[g] = pick(srcVec, A) ^ ~pick(srcVec, B);
    end
  end
endmodule

// File: rtl/scan_tree_cells.sv
module scan_tree_cells #(
  parameter int N = scan_tree_pkg::DEF_CELLS
) (
  input  logic                   clk,
  input  scan_tree_pkg::strobe_t stb,
  input  logic [N-1:0]           shiftD,
  input  logic [N-1:0]           funcD,
  output logic [N-1:0]           cellQ
);
  always_ff @(posedge clk) begin
    if (stb.clear)        cellQ <= '0;
    else if (stb.shift)   cellQ <= shiftD;
    else if (stb.capture) cellQ <= funcD;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (stb.clear)
    $past(stb.clear) |-> cellQ == '0);  // R1
  AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (stb.clear)
    $past(stb.capture) |-> cellQ == $past(funcD));  // R2
endmodule

// File: rtl/scan_tree.sv
module scan_tree #(
  parameter int N = scan_tree_pkg::DEF_CELLS,
  parameter int M = scan_tree_pkg::DEF_TAPS_N,
  parameter scan_tree_pkg::link_t [N-1:0] LINKS = scan_tree_pkg::DEF_LINKS,
  parameter logic [M-1:0][7:0] TAPS = scan_tree_pkg::DEF_TAPS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_in,
  input  logic         scan_enable,
  input  logic [N-1:0] func_d,
  output logic [M-1:0] scan_out,
  output logic [N-1:0] q
);
  import scan_tree_pkg::*;

  strobe_t      stb;
  logic [N-1:0] shiftD;
  logic [N-1:0] cellQ;
  logic [N:0]   srcVec;

  scan_tree_ctrl uCtrl (
    .rstN(rst_n), .scanEnable(scan_enable), .stb(stb)
  );

  scan_tree_links #(.N(N), .LINKS(LINKS)) uLinks (
    .scanIn(scan_in), .cellQ(cellQ), .shiftD(shiftD)
  );

  scan_tree_cells #(.N(N)) uCells (
    .clk(clk), .stb(stb), .shiftD(shiftD), .funcD(func_d), .cellQ(cellQ)
  );

  assign q = cellQ;
  assign srcVec = {scan_in, cellQ};

  for (genvar k = 0; k < M; k++) begin : gTap
    localparam int T = int'(TAPS[k]);
    assign scan_out[k] = cellQ[T];
  end

  for (genvar g = 0; g < N; g++) begin : gChk
    localparam int A = int'(LINKS[g].srcA);
    localparam int B = int'(LINKS[g].srcB);
    if (LINKS[g].kind == LK_COPY) begin : gCopy
      AST_COPY_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && scan_enable) |-> q[g] == $past(srcVec[A]));  // R3
    end else if (LINKS[g].kind == LK_INV) begin : gInv
      AST_INV_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && scan_enable) |-> q[g] == !$past(srcVec[A]));  // R4
    end else if (LINKS[g].kind == LK_XOR) begin : gXor
      AST_XOR_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && scan_enable) |-> q[g] == ($past(srcVec[A]) ^ $past(srcVec[B])));  // R5
    end else begin : gXnor
      AST_XNOR_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && scan_enable) |-> q[g] == ($past(srcVec[A]) ^ !$past(srcVec[B])));  // R6
    end
  end
endmodule

// File: tb/scan_tree_test.sv
`timescale 1ns/1ps
module scan_tree_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rstN = 1'b0, scanEnable = 1'b0, scanIn = 1'b0;
  logic [8:0] funcD = '0;
  logic [3:0] scanOut;
  logic [8:0] q;

  scan_tree uut (
    .clk(clk), .rst_n(rstN), .scan_in(scanIn), .scan_enable(scanEnable),
    .func_d(funcD), .scan_out(scanOut), .q(q)
  );

  int total = 0, bad = 0;
  logic [8:0]  expQ = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] want);
    total++;
    if (act !== want) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, want);
    end
  endtask

  // Default link table written out independently.
  function automatic logic [8:0] model(input logic [8:0] c, input logic si);
    logic [8:0] n;
    n[0] = si;       n[1] = ~si;        n[2] = si;
    n[3] = c[0];     n[4] = ~c[0];      n[5] = ~c[2];
    n[6] = c[3];     n[7] = c[3] ^ c[0]; n[8] = c[4] ^ ~c[2];
    return n;
  endfunction

  function automatic logic [3:0] taps(input logic [8:0] c);
    return {c[5], c[8], c[7], c[6]};
  endfunction

  function automatic string cellTag(input int i);
    case (i)
      1, 4, 5: return "R4";
      7:       return "R5";
      8:       return "R6";
      default: return "R3";
    endcase
  endfunction

  task automatic step(input logic rn, input logic se, input logic si, input logic [8:0] fd);
    rstN = rn; scanEnable = se; scanIn = si; funcD = fd;
    @(posedge clk);
    if (!rn)     expQ = '0;
    else if (se) expQ = model(expQ, si);
    else         expQ = fd;
    @(negedge clk);
    if (!rn) chk(se ? "R9 reset over shift" : "R1 reset", q, 0);
    else if (!se) chk("R2 capture", q, expQ);
    else for (int i = 0; i < 9; i++) chk(cellTag(i), q[i], expQ[i]);
    chk("R8 taps", scanOut, taps(expQ));
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    @(negedge clk);
    step(1'b0, 1'b0, 1'b0, 9'h1FF);   // R1
    step(1'b1, 1'b0, 1'b0, 9'h155);   // R2
    step(1'b0, 1'b1, 1'b1, 9'h1FF);   // R9
    // R2 sweep over every functional word
    for (int v = 0; v < 512; v++) step(1'b1, 1'b0, v[0], v[8:0]);
    // R7 every 3-bit pattern from a scrambled state
    for (int p = 0; p < 8; p++) begin
      logic b1, b2, b3;
      b1 = p[2]; b2 = p[1]; b3 = p[0];
      step(1'b1, 1'b0, 1'b0, 9'h1A5 ^ 9'(p * 37));
      step(1'b1, 1'b1, b1, 9'h0);
      step(1'b1, 1'b1, b2, 9'h1FF);
      step(1'b1, 1'b1, b3, 9'h0);
      chk("R7 load in depth", q,
          {b1 ^ b2, b1 ^ b2, b1, ~b2, ~b2, b2, b3, ~b3, b3});
    end
    // Mixed pseudo-random run
    for (int n = 0; n < 3000; n++) begin
      lfsr = nextLfsr(lfsr);
      step(lfsr[7:0] != 8'h00, lfsr[3] | lfsr[5], lfsr[9], lfsr[15:7]);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule